// File: doc/BRIEF.md
# Sparse Delta Gate Accumulator

This block keeps the pre-activation sums of a three-gate recurrent layer current without recomputing the full matrix-vector product each time step. It receives only the elements of the input vector and of the hidden vector that changed, as value/index pairs, with up to two pairs per clock. Each pair selects one weight column from an on-chip memory with two read ports. The block multiplies the column by the change and adds the result into accumulators that persist across time steps.

There are three gate channels: reset, update and candidate. The reset and update channels each hold one sum per row. The candidate channel holds two sums per row: one fed only by input-vector changes and one fed only by hidden-vector changes, so that a later stage can scale the hidden part on its own. Within a step, the input-vector changes arrive first and end with an end-of-vector mark, and the hidden-vector changes follow. A one-cycle done pulse shows that the step's sums are final. Weights are preloaded through a plain write port. The bias values are loaded into the accumulators at reset.

Top module: `delta_mxv_acc`

## Requirements
- R1: While `rst` is high, every row of `pre_r`, `pre_u` and `pre_cx` loads the matching slice of `bias_r`, `bias_u` and `bias_c`, and `pre_ch` clears to zero. After reset the step starts in the input phase with `step_done` low.
- R2: Take a valid lane with `dl_hid` low, a change d and an index i. For every row it adds the weight times d of column i to `pre_r`, `pre_u` and `pre_cx`, and leaves `pre_ch` unchanged.
- R3: Take a valid lane with `dl_hid` high, a change d and an index j. For every row it adds the weight times d of column IN_LEN+j to `pre_r`, `pre_u` and `pre_ch`, and leaves `pre_cx` unchanged.
- R4: Both lanes of a beat are applied in the same update, including when they name the same column. A lane whose `dl_valid` bit is low adds nothing, whatever its index and value.
- R5: No sum is cleared at a step boundary. The next step's changes add onto the values the previous step left.
- R6: A beat sampled on clock edge E shows up on the `pre_*` outputs right after edge E+2. It is not visible before that edge.
- R7: The first `dl_last` of a step ends the input phase and the second ends the hidden phase. Let E be the edge that samples the second `dl_last`. `step_done` is then high for exactly one cycle, from edge E+2 to edge E+3, and the next step accepts beats from edge E+4 on.
- R8: Changes and weights are signed Q8.8, products are signed Q16.16, and the sums are signed Q16.16 that wrap modulo 2^32.
- R9: When `wr_en` is high, `wr_data` is stored as weight column `wr_addr`. Input-vector column i sits at address i and hidden-vector column j at address IN_LEN+j. Within a column word, the weight for row r of channel k (reset 0, update 1, candidate 2) occupies bits [(k*ROWS+r)*16 +: 16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the biases |
| bias_r | input | ROWS*AW | Reset-channel bias per row, Q16.16 |
| bias_u | input | ROWS*AW | Update-channel bias per row, Q16.16 |
| bias_c | input | ROWS*AW | Candidate input-side bias per row, Q16.16 |
| wr_en | input | 1 | Weight column write strobe |
| wr_addr | input | CAW | Weight column address |
| wr_data | input | 3*ROWS*VW | Weight column contents |
| dl_valid | input | 2 | Per-lane valid for the change pairs |
| dl_hid | input | 1 | Beat carries hidden-vector changes |
| dl_last | input | 1 | Beat closes the current vector |
| dl_val | input | 2*VW | Change values, lane 0 in the low half |
| dl_idx | input | 2*IDXW | Change indices, lane 0 in the low part |
| pre_r | output | ROWS*AW | Reset-channel sums |
| pre_u | output | ROWS*AW | Update-channel sums |
| pre_cx | output | ROWS*AW | Candidate sums from input changes |
| pre_ch | output | ROWS*AW | Candidate sums from hidden changes |
| step_done | output | 1 | One-cycle pulse when the step's sums are final |

## Verification
The assertions assume well-behaved input. A beat's `dl_hid` flag matches the phase the block is in. Every valid index lies inside its own vector. No lane is valid and `dl_last` stays low from the closing hidden beat until the step's done pulse has passed. Weight writes happen only on beats with no valid lane. The stimulus keeps to these rules: it loads all weight columns before the first change pair, marks each beat's source to match its phase, and follows every closing hidden beat with three empty beats. The bench predicts every output cycle by cycle. It covers beats with a disabled lane carrying a junk index, two lanes on one column, empty end-of-vector beats, and a bias placed near the positive limit so that the first update wraps.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
   localparam int LANES = 2;
   localparam int NCH   = 3;
   localparam int CH_R  = 0;
   localparam int CH_U  = 1;
   localparam int CH_C  = 2;

   typedef enum logic [1:0] {
      PH_X     = 2'd0,
      PH_H     = 2'd1,
      PH_DRAIN = 2'd2,
      PH_DONE  = 2'd3
   } phase_t;
endpackage

// File: rtl/dmv_wram.sv
module dmv_wram #(
   parameter int WORDS = 16,
   parameter int ABITS = 4,
   parameter int WW    = 192
) (
   input  logic             clk,
   input  logic             a_we,
   input  logic             a_re,
   input  logic [ABITS-1:0] a_addr,
   input  logic [WW-1:0]    a_wdata,
   output logic [WW-1:0]    a_rdata,
   input  logic             b_re,
   input  logic [ABITS-1:0] b_addr,
   output logic [WW-1:0]    b_rdata
);
   generate
      if (WORDS < 2) begin : g_bad_words
         $error("dmv_wram: WORDS must be at least 2");
      end
      if ((1 << ABITS) < WORDS) begin : g_bad_abits
         $error("dmv_wram: ABITS too small for WORDS");
      end
   endgenerate

   logic [WW-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (a_we)
         store[a_addr] <= a_wdata;
      if (a_re)
         a_rdata <= store[a_addr];
   end

   always_ff @(posedge clk) begin
      if (b_re)
         b_rdata <= store[b_addr];
   end
endmodule

// File: rtl/dmv_lane_mul.sv
module dmv_lane_mul #(
   parameter int ELEMS = 12,
   parameter int VW    = 16,
   parameter int PW    = 32
) (
   input  logic [ELEMS*VW-1:0] col,
   input  logic [VW-1:0]       delta,
   input  logic                en,
   output logic [ELEMS*PW-1:0] prod
);
   generate
      if (PW != 2 * VW) begin : g_bad_pw
         $error("dmv_lane_mul: PW must be twice VW");
      end
   endgenerate

   logic signed [PW-1:0] dx;
   assign dx = PW'($signed(delta));

   generate
      for (genvar k = 0; k < ELEMS; k++) begin : g_el
         logic signed [PW-1:0] wx;
         assign wx = PW'($signed(col[k*VW +: VW]));
         assign prod[k*PW +: PW] = en ? (wx * dx) : '0;
      end
   endgenerate
endmodule

// File: rtl/dmv_acc_bank.sv
module dmv_acc_bank
   import dmv_pkg::*;
#(
   parameter int ROWS = 4,
   parameter int PW   = 32,
   parameter int AW   = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ROWS*AW-1:0]    bias_r,
   input  logic [ROWS*AW-1:0]    bias_u,
   input  logic [ROWS*AW-1:0]    bias_c,
   input  logic [NCH*ROWS*PW-1:0] p0,
   input  logic [NCH*ROWS*PW-1:0] p1,
   input  logic [LANES-1:0]      v,
   input  logic                  hid,
   output logic [ROWS*AW-1:0]    pre_r,
   output logic [ROWS*AW-1:0]    pre_u,
   output logic [ROWS*AW-1:0]    pre_cx,
   output logic [ROWS*AW-1:0]    pre_ch
);
   generate
      if (AW < PW) begin : g_bad_aw
         $error("dmv_acc_bank: AW must hold a full product");
      end
   endgenerate

   logic upd;
   assign upd = |v;

   generate
      for (genvar rw = 0; rw < ROWS; rw++) begin : g_row
         logic signed [AW-1:0] sum [NCH];
         for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            logic signed [AW-1:0] e0, e1;
            assign e0 = AW'($signed(p0[(ch*ROWS+rw)*PW +: PW]));
            assign e1 = AW'($signed(p1[(ch*ROWS+rw)*PW +: PW]));
            assign sum[ch] = e0 + e1;
         end

         logic signed [AW-1:0] r_q, u_q, cx_q, ch_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               r_q  <= bias_r[rw*AW +: AW];
               u_q  <= bias_u[rw*AW +: AW];
               cx_q <= bias_c[rw*AW +: AW];
               ch_q <= '0;
            end else if (upd) begin
               r_q <= r_q + sum[CH_R];
               u_q <= u_q + sum[CH_U];
               if (hid)
                  ch_q <= ch_q + sum[CH_C];
               else
                  cx_q <= cx_q + sum[CH_C];
            end
         end

         assign pre_r[rw*AW +: AW]  = r_q;
         assign pre_u[rw*AW +: AW]  = u_q;
         assign pre_cx[rw*AW +: AW] = cx_q;
         assign pre_ch[rw*AW +: AW] = ch_q;
      end
   endgenerate

   // R2: input-side updates leave the hidden-side candidate sums alone
   a_r2_ch_hold: assert property (@(posedge clk) disable iff (rst)
      (upd && !hid) |=> $stable(pre_ch));

   // R3: hidden-side updates leave the input-side candidate sums alone
   a_r3_cx_hold: assert property (@(posedge clk) disable iff (rst)
      (upd && hid) |=> $stable(pre_cx));

   // R4: with no valid lane in the last stage, nothing moves
   a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable({pre_r, pre_u, pre_cx, pre_ch}));
endmodule

// File: rtl/delta_mxv_acc.sv
module delta_mxv_acc
   import dmv_pkg::*;
#(
   parameter int ROWS    = 4,
   parameter int IN_LEN  = 6,
   parameter int HID_LEN = 8,
   parameter int VW      = 16,
   parameter int AW      = 32,
   localparam int MAXLEN = (IN_LEN > HID_LEN) ? IN_LEN : HID_LEN,
   localparam int IDXW   = (MAXLEN > 1) ? $clog2(MAXLEN) : 1,
   localparam int CAW    = $clog2(IN_LEN + HID_LEN)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ROWS*AW-1:0]   bias_r,
   input  logic [ROWS*AW-1:0]   bias_u,
   input  logic [ROWS*AW-1:0]   bias_c,
   input  logic                 wr_en,
   input  logic [CAW-1:0]       wr_addr,
   input  logic [3*ROWS*VW-1:0] wr_data,
   input  logic [1:0]           dl_valid,
   input  logic                 dl_hid,
   input  logic                 dl_last,
   input  logic [2*VW-1:0]      dl_val,
   input  logic [2*IDXW-1:0]    dl_idx,
   output logic [ROWS*AW-1:0]   pre_r,
   output logic [ROWS*AW-1:0]   pre_u,
   output logic [ROWS*AW-1:0]   pre_cx,
   output logic [ROWS*AW-1:0]   pre_ch,
   output logic                 step_done
);
   localparam int PW    = 2 * VW;
   localparam int WORDS = IN_LEN + HID_LEN;
   localparam int COLW  = NCH * ROWS * VW;
   localparam int PRW   = NCH * ROWS * PW;

   generate
      if (ROWS < 1) begin : g_bad_rows
         $error("delta_mxv_acc: ROWS must be positive");
      end
      if (IN_LEN < 1 || HID_LEN < 1) begin : g_bad_len
         $error("delta_mxv_acc: vector lengths must be positive");
      end
      if (AW < PW) begin : g_bad_aw
         $error("delta_mxv_acc: AW must be at least 2*VW");
      end
   endgenerate

   // ---------------- step sequencing ----------------
   phase_t phase;
   logic   drain_cnt;
   logic   accept;
   logic [LANES-1:0] go;

   assign accept = (phase == PH_X) || (phase == PH_H);
   assign go     = dl_valid & {LANES{accept}};

   always_ff @(posedge clk) begin
      if (rst) begin
         phase     <= PH_X;
         drain_cnt <= 1'b0;
      end else begin
         unique case (phase)
            PH_X: if (dl_last) phase <= PH_H;
            PH_H: if (dl_last) begin
               phase     <= PH_DRAIN;
               drain_cnt <= 1'b0;
            end
            PH_DRAIN: begin
               if (drain_cnt) phase <= PH_DONE;
               drain_cnt <= 1'b1;
            end
            PH_DONE: phase <= PH_X;
         endcase
      end
   end

   assign step_done = (phase == PH_DONE);

   // ---------------- column fetch ----------------
   logic [CAW-1:0]  rd_addr [LANES];
   logic [COLW-1:0] col     [LANES];

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_addr
         assign rd_addr[l] = CAW'(dl_idx[l*IDXW +: IDXW])
                           + (dl_hid ? CAW'(IN_LEN) : CAW'(0));
      end
   endgenerate

   dmv_wram #(.WORDS(WORDS), .ABITS(CAW), .WW(COLW)) u_wram (
      .clk     (clk),
      .a_we    (wr_en),
      .a_re    (go[0]),
      .a_addr  (wr_en ? wr_addr : rd_addr[0]),
      .a_wdata (wr_data),
      .a_rdata (col[0]),
      .b_re    (go[1]),
      .b_addr  (rd_addr[1]),
      .b_rdata (col[1])
   );

   // ---------------- stage 1: change alongside the column read ----------------
   logic [LANES-1:0] s1_v;
   logic [2*VW-1:0]  s1_val;
   logic             s1_hid;

   always_ff @(posedge clk) begin
      if (rst) s1_v <= '0;
      else     s1_v <= go;
      s1_val <= dl_val;
      s1_hid <= dl_hid;
   end

   // ---------------- stage 2: registered products ----------------
   logic [PRW-1:0]   prod [LANES];
   logic [PRW-1:0]   s2_p [LANES];
   logic [LANES-1:0] s2_v;
   logic             s2_hid;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_mul
         dmv_lane_mul #(.ELEMS(NCH*ROWS), .VW(VW), .PW(PW)) u_mul (
            .col   (col[l]),
            .delta (s1_val[l*VW +: VW]),
            .en    (s1_v[l]),
            .prod  (prod[l])
         );
         always_ff @(posedge clk) s2_p[l] <= prod[l];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) s2_v <= '0;
      else     s2_v <= s1_v;
      s2_hid <= s1_hid;
   end

   // ---------------- stage 3: accumulate ----------------
   dmv_acc_bank #(.ROWS(ROWS), .PW(PW), .AW(AW)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .bias_r (bias_r),
      .bias_u (bias_u),
      .bias_c (bias_c),
      .p0     (s2_p[0]),
      .p1     (s2_p[1]),
      .v      (s2_v),
      .hid    (s2_hid),
      .pre_r  (pre_r),
      .pre_u  (pre_u),
      .pre_cx (pre_cx),
      .pre_ch (pre_ch)
   );

   // ---------------- input contract and sequencing checks ----------------
   // R7: beat source matches the phase
   a_r7_order_x: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_X && |dl_valid) |-> !dl_hid);
   a_r7_order_h: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_H && |dl_valid) |-> dl_hid);
   // R7: quiet between the closing hidden beat and the next step
   a_r7_quiet_drain: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_DRAIN || phase == PH_DONE) |-> (!(|dl_valid) && !dl_last));
   // R7: done is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
      step_done |=> !step_done);
   // R7: done follows the closing hidden beat by a fixed distance
   a_r7_done_timing: assert property (@(posedge clk) disable iff (rst)
      step_done |-> $past(phase == PH_H && dl_last, 3));
   // R9: no weight write while a lane reads
   a_r9_write_idle: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !(|dl_valid));

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_idx_chk
         // R9: valid indices stay inside their vector
         a_r9_idx_x: assert property (@(posedge clk) disable iff (rst)
            (dl_valid[l] && !dl_hid) |-> ({1'b0, dl_idx[l*IDXW +: IDXW]} < (IDXW+1)'(IN_LEN)));
         a_r9_idx_h: assert property (@(posedge clk) disable iff (rst)
            (dl_valid[l] && dl_hid) |-> ({1'b0, dl_idx[l*IDXW +: IDXW]} < (IDXW+1)'(HID_LEN)));
      end
   endgenerate
endmodule

// File: tb/delta_mxv_acc_test.sv
module delta_mxv_acc_test;
   localparam int CLK_NS  = 10;
   localparam int ROWS    = 4;
   localparam int IN_LEN  = 6;
   localparam int HID_LEN = 8;
   localparam int VW      = 16;
   localparam int AW      = 32;
   localparam int IDXW    = 3;
   localparam int CAW     = 4;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic [ROWS*AW-1:0]   bias_r, bias_u, bias_c;
   logic                 wr_en = 1'b0;
   logic [CAW-1:0]       wr_addr = '0;
   logic [3*ROWS*VW-1:0] wr_data = '0;
   logic [1:0]           dl_valid = '0;
   logic                 dl_hid = 1'b0;
   logic                 dl_last = 1'b0;
   logic [2*VW-1:0]      dl_val = '0;
   logic [2*IDXW-1:0]    dl_idx = '0;
   logic [ROWS*AW-1:0]   pre_r, pre_u, pre_cx, pre_ch;
   logic                 step_done;

   delta_mxv_acc #(.ROWS(ROWS), .IN_LEN(IN_LEN), .HID_LEN(HID_LEN), .VW(VW), .AW(AW)) uut (
      .clk(clk), .rst(rst), .bias_r(bias_r), .bias_u(bias_u), .bias_c(bias_c),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dl_valid(dl_valid), .dl_hid(dl_hid), .dl_last(dl_last),
      .dl_val(dl_val), .dl_idx(dl_idx),
      .pre_r(pre_r), .pre_u(pre_u), .pre_cx(pre_cx), .pre_ch(pre_ch),
      .step_done(step_done)
   );

   always #(CLK_NS/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // reference sums
   int m_r [ROWS], m_u [ROWS], m_cx [ROWS], m_ch [ROWS];

   // scoreboard queues
   int    expq [$];
   int    dueq [$];
   bit    doneq [$];
   string tagq [$];

   function automatic int wgt(int c, int ch, int row);
      return (((c * 5 + ch * 3 + row * 7) % 17) + 1) * 24;
   endfunction

   function automatic void apply(int c, int d, bit hid);
      for (int row = 0; row < ROWS; row++) begin
         m_r[row] += wgt(c, 0, row) * d;
         m_u[row] += wgt(c, 1, row) * d;
         if (hid) m_ch[row] += wgt(c, 2, row) * d;
         else     m_cx[row] += wgt(c, 2, row) * d;
      end
   endfunction

   task automatic beat(input bit v0, input int i0, input int d0,
                       input bit v1, input int i1, input int d1,
                       input bit hid, input bit last, input string tag);
      int base;
      dl_valid = {v1, v0};
      dl_idx   = {IDXW'(i1), IDXW'(i0)};
      dl_val   = {16'(d1), 16'(d0)};
      dl_hid   = hid;
      dl_last  = last;
      base = hid ? IN_LEN : 0;
      if (v0) apply(base + i0, d0, hid);
      if (v1) apply(base + i1, d1, hid);
      for (int row = 0; row < ROWS; row++) begin
         expq.push_back(m_r[row]);
         expq.push_back(m_u[row]);
         expq.push_back(m_cx[row]);
         expq.push_back(m_ch[row]);
      end
      dueq.push_back(cyc + 3);
      doneq.push_back(hid && last);
      tagq.push_back(tag);
      @(negedge clk);
      dl_valid = '0;
      dl_last  = 1'b0;
   endtask

   task automatic idle3(input string tag);
      for (int k = 0; k < 3; k++) beat(0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   // monitor: pops expected state when it is due
   int    e_v [4];
   int    a_v [4];
   bit    e_done;
   string m_tag;
   bit    m_bad;
   string m_nm;
   always @(negedge clk) begin
      if (!finished && dueq.size() > 0 && dueq[0] == cyc) begin
         void'(dueq.pop_front());
         e_done = doneq.pop_front();
         m_tag  = tagq.pop_front();
         m_bad  = 0;
         for (int row = 0; row < ROWS; row++) begin
            for (int f = 0; f < 4; f++) e_v[f] = expq.pop_front();
            a_v[0] = $signed(pre_r[row*AW +: AW]);
            a_v[1] = $signed(pre_u[row*AW +: AW]);
            a_v[2] = $signed(pre_cx[row*AW +: AW]);
            a_v[3] = $signed(pre_ch[row*AW +: AW]);
            for (int f = 0; f < 4; f++) begin
               if (!m_bad && a_v[f] != e_v[f]) begin
                  m_bad = 1;
                  m_nm = (f == 0) ? "pre_r" : (f == 1) ? "pre_u" : (f == 2) ? "pre_cx" : "pre_ch";
                  $display("FAIL %s cyc=%0d row=%0d %s act=%0d exp=%0d",
                           m_tag, cyc, row, m_nm, a_v[f], e_v[f]);
               end
            end
         end
         if (!m_bad && step_done != e_done) begin
            m_bad = 1;
            $display("FAIL %s R7 cyc=%0d step_done act=%0d exp=%0d", m_tag, cyc, step_done, e_done);
         end
         total++;
         if (m_bad) bad++;
      end
   end

   task automatic check_reset();
      bit rb;
      rb = 0;
      for (int row = 0; row < ROWS; row++) begin
         if (pre_r[row*AW +: AW] != bias_r[row*AW +: AW] ||
             pre_u[row*AW +: AW] != bias_u[row*AW +: AW] ||
             pre_cx[row*AW +: AW] != bias_c[row*AW +: AW] ||
             pre_ch[row*AW +: AW] != '0) begin
            if (!rb)
               $display("FAIL R1 row=%0d act=%0d/%0d/%0d/%0d exp=%0d/%0d/%0d/0", row,
                        $signed(pre_r[row*AW +: AW]), $signed(pre_u[row*AW +: AW]),
                        $signed(pre_cx[row*AW +: AW]), $signed(pre_ch[row*AW +: AW]),
                        m_r[row], m_u[row], m_cx[row]);
            rb = 1;
         end
      end
      if (step_done !== 1'b0) begin
         if (!rb) $display("FAIL R1 step_done act=%0d exp=0", step_done);
         rb = 1;
      end
      total++;
      if (rb) bad++;
   endtask

   initial begin
      // biases: row 3 of the update channel sits near the positive limit (R8)
      for (int row = 0; row < ROWS; row++) begin
         m_r[row]  = (row + 1) * 65536;
         m_u[row]  = (row == 3) ? 32'sh7FFF_FFF0 : -(row + 1) * 32768;
         m_cx[row] = row * 4096 + 7;
         m_ch[row] = 0;
         bias_r[row*AW +: AW] = m_r[row];
         bias_u[row*AW +: AW] = m_u[row];
         bias_c[row*AW +: AW] = m_cx[row];
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check_reset();   // R1

      // preload every column (R9)
      for (int c = 0; c < IN_LEN + HID_LEN; c++) begin
         wr_en   = 1'b1;
         wr_addr = CAW'(c);
         for (int ch = 0; ch < 3; ch++)
            for (int row = 0; row < ROWS; row++)
               wr_data[(ch*ROWS+row)*16 +: 16] = 16'(wgt(c, ch, row));
         @(negedge clk);
      end
      wr_en = 1'b0;
      @(negedge clk);

      // step 1
      beat(1, 0, 256,  1, 1, 256,   0, 0, "R2/R8/R9 dual input lanes");
      beat(1, 2, -128, 0, 7, 12345, 0, 0, "R4 lane1 off");
      beat(0, 4, 500,  1, 5, 576,   0, 0, "R4/R6 lane0 off");
      beat(0, 0, 0,    0, 0, 0,     0, 0, "R6 idle");
      beat(1, 3, 256,  1, 3, -128,  0, 1, "R4 same column input last");
      beat(1, 0, 384,  1, 7, -256,  1, 0, "R3 hidden pair");
      beat(0, 0, 0,    1, 4, 200,   1, 0, "R3 hidden lane1");
      beat(1, 5, -77,  1, 6, 333,   1, 1, "R3/R7 hidden last");
      idle3("R7 drain");

      // step 2 continues from step 1's sums
      beat(0, 0, 0,    0, 0, 0,     0, 1, "R5/R7 empty input last");
      beat(1, 1, -300, 1, 2, 150,   1, 0, "R5 hidden pair");
      beat(1, 7, 100,  0, 0, 0,     1, 1, "R5/R7 hidden last");
      idle3("R5/R7 drain");

      // step 3: both vectors empty
      beat(0, 0, 0, 0, 0, 0, 0, 1, "R7 empty step input");
      beat(0, 0, 0, 0, 0, 0, 1, 1, "R7 empty step hidden");
      idle3("R7 empty drain");

      while (dueq.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL R7 watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule